// File: doc/BRIEF.md
# Weighted Grayscale Binarizer

This block turns a stream of RGB pixels into a single intensity value per pixel and, when asked, reduces that intensity to a pure black-or-white level. It is meant to sit ahead of an edge detector. A hard two-level image gives the edge detector the sharpest possible gradients.

Each qualified input pixel carries three 10-bit colour components. The block weights green twice as heavily as red and blue. It forms the 12-bit sum red + 2·green + blue using only adders and a wire shift, and brings the sum back to 10 bits by dropping its two low bits.

A mode input selects the output:

- With binarization off, the 10-bit gray level goes out unchanged.
- With binarization on, that level is compared with a runtime 10-bit threshold. The output is then either full white (1023) or black (0).

The output is registered one cycle behind the input and carries its own valid flag.

Top module: `gray_binarizer`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_pixel` is 0.
- R2: `out_valid` equals the previous cycle's `in_valid`, so every accepted pixel yields exactly one output pixel one clock later.
- R3: With `bin_en` = 0, the output pixel is (red + 2·green + blue) >> 2, computed without loss in 12 bits.
- R4: With `bin_en` = 1, the output pixel is 1023 when ((red + 2·green + blue) >> 2) ≥ `thresh`, and 0 otherwise.
- R5: Equality with the threshold gives white. A threshold of 0 makes every pixel white, and a level one below the threshold gives black.
- R6: On a cycle with `in_valid` = 0, `out_pixel` keeps its previous value. Changes to `thresh`, `bin_en` or the colour inputs on such a cycle have no effect on any output.
- R7: Full-scale components (all three at 1023) give a pass-through level of 1023 with no wrap-around.
- R8: With `bin_en` = 1, the output pixel is only ever 0 or 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel qualifier |
| in_red | input | 10 | Red component |
| in_green | input | 10 | Green component |
| in_blue | input | 10 | Blue component |
| thresh | input | 10 | Binarization threshold, sampled on valid cycles |
| bin_en | input | 1 | 1 = black/white output, 0 = gray pass-through |
| out_valid | output | 1 | Output pixel qualifier |
| out_pixel | output | 10 | Gray level or binarized level (0 = black, 1023 = white) |

## Verification
The bench sweeps a grid of colour values in both modes and compares each result with the arithmetic formula.

It walks the threshold across a fixed gray level to pin down where the comparison switches. A design using a strict comparison would turn the equality case black. A design that truncates the sum to 10 bits would wrap at full-scale colour.

Idle cycles carry changed threshold, mode and colour values. This exposes a design that updates or re-qualifies its output without a valid pixel. Back-to-back valid pixels expose any dropped or duplicated output.

// File: rtl/gray_pkg.sv
package gray_pkg;
    localparam int COMP_W = 10;
    localparam int SUM_W  = COMP_W + 2;
    localparam int DROP_W = SUM_W - COMP_W;

    typedef logic [COMP_W-1:0] comp_t;
    typedef logic [SUM_W-1:0]  sum_t;

    typedef struct packed {
        logic  valid;
        comp_t pixel;
    } out_state_t;
endpackage

// File: rtl/gray_weight_sum.sv
module gray_weight_sum
    import gray_pkg::*;
(
    input  comp_t red,
    input  comp_t green,
    input  comp_t blue,
    output sum_t  wsum,
    output comp_t level
);
    sum_t red_x, green_x2, blue_x;

    always_comb begin
        red_x    = sum_t'(red);
        green_x2 = sum_t'(green) << 1;
        blue_x   = sum_t'(blue);
        wsum     = red_x + green_x2 + blue_x;
        level    = wsum[SUM_W-1:DROP_W];
    end
endmodule

// File: rtl/gray_level_slicer.sv
module gray_level_slicer
    import gray_pkg::*;
(
    input  comp_t level,
    input  comp_t thresh,
    input  logic  bin_en,
    output comp_t result
);
    localparam comp_t WHITE = '1;
    localparam comp_t BLACK = '0;

    logic above;

    always_comb begin
        above  = (level >= thresh);
        result = bin_en ? (above ? WHITE : BLACK) : level;
    end
endmodule

// File: rtl/gray_binarizer.sv
module gray_binarizer
    import gray_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [COMP_W-1:0] in_red,
    input  logic [COMP_W-1:0] in_green,
    input  logic [COMP_W-1:0] in_blue,
    input  logic [COMP_W-1:0] thresh,
    input  logic              bin_en,
    output logic              out_valid,
    output logic [COMP_W-1:0] out_pixel
);
    localparam comp_t FULL = '1;

    sum_t       wsum;
    comp_t      level;
    comp_t      sliced;
    out_state_t st_d, st_q;

    gray_weight_sum u_sum (
        .red   (in_red),
        .green (in_green),
        .blue  (in_blue),
        .wsum  (wsum),
        .level (level)
    );

    gray_level_slicer u_slice (
        .level  (level),
        .thresh (thresh),
        .bin_en (bin_en),
        .result (sliced)
    );

    // Threshold and mode only matter on valid cycles; idle cycles hold the pixel.
    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.pixel = sliced;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_pixel = st_q.pixel;

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_pixel));

    p_two_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bin_en) |=> (out_pixel == '0 || out_pixel == FULL));

    p_full_scale_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bin_en && in_red == FULL && in_green == FULL && in_blue == FULL)
        |=> out_pixel == FULL);

    p_zero_thresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bin_en && thresh == '0) |=> out_pixel == FULL);
endmodule

// File: tb/tb_gray_binarizer.sv
`timescale 1ns/1ps
module tb_gray_binarizer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_red = '0, in_green = '0, in_blue = '0, thresh = '0;
    logic       bin_en = 1'b0;
    logic       out_valid;
    logic [9:0] out_pixel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gray_binarizer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_red(in_red), .in_green(in_green), .in_blue(in_blue),
        .thresh(thresh), .bin_en(bin_en),
        .out_valid(out_valid), .out_pixel(out_pixel)
    );

    function automatic logic [9:0] model(input int r, input int g, input int b,
                                         input int t, input bit m);
        int lvl;
        lvl = (r + 2*g + b) >> 2;
        if (!m) return 10'(lvl);
        return (lvl >= t) ? 10'd1023 : 10'd0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at negedge; the register captures at the next posedge; sample at the following negedge.
    task automatic send(input int r, input int g, input int b, input int t,
                        input bit m, input string req);
        in_valid = 1'b1; in_red = 10'(r); in_green = 10'(g); in_blue = 10'(b);
        thresh = 10'(t); bin_en = m;
        @(negedge clk);
        check(req, int'(out_valid), 1);
        check(req, int'(out_pixel), int'(model(r, g, b, t, m)));
    endtask

    initial begin
        logic [9:0] held;
        @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_pixel), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 / R4 / R8: grid sweep in both modes
        for (int m = 0; m < 2; m++)
            for (int r = 0; r < 1024; r += 93)
                for (int g = 0; g < 1024; g += 93)
                    for (int b = 0; b < 1024; b += 93)
                        send(r, g, b, (r * 7 + g * 3 + b) % 1024, bit'(m), m ? "R4" : "R3");

        // R7: full scale
        send(1023, 1023, 1023, 0, 1'b0, "R7");
        send(1023, 0, 1023, 0, 1'b0, "R7");
        send(0, 1023, 0, 0, 1'b0, "R7");

        // R5: threshold walk around level (400+2*300+200)>>2 = 300
        for (int t = 290; t <= 310; t++) send(400, 300, 200, t, 1'b1, "R5");
        send(0, 0, 0, 0, 1'b1, "R5");
        send(1023, 1023, 1023, 1023, 1'b1, "R5");

        // R6: idle cycles with changed controls must not disturb the output
        send(100, 200, 300, 0, 1'b0, "R6");
        held = out_pixel;
        in_valid = 1'b0; in_red = 10'd1023; in_green = 10'd1023; in_blue = 10'd1023;
        thresh = 10'd0; bin_en = 1'b1;
        @(negedge clk);
        check("R6", int'(out_valid), 0);
        check("R6", int'(out_pixel), int'(held));
        thresh = 10'd1023; bin_en = 1'b0;
        @(negedge clk);
        check("R6", int'(out_valid), 0);
        check("R6", int'(out_pixel), int'(held));

        // R2: back-to-back then gap
        send(10, 20, 30, 0, 1'b0, "R2");
        send(40, 50, 60, 0, 1'b0, "R2");
        in_valid = 1'b0;
        @(negedge clk);
        check("R2", int'(out_valid), 0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule